// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block identifies an attached display by probing three shared open-drain identification lines, called A, B and C here. A one-cycle `start_i` request launches a fixed probe. First all three lines are driven high briefly to charge them. Then every driver is let go and the lines are left to settle. After that, each line in turn (A, then B, then C) is pulled low while the other two are read. The levels read back are packed into an 11-bit sense code. The code leaves the block together with a one-cycle `done_o` pulse, and it is held until the next probe completes.

The lines reach the block through `line_i`. Each bit passes through a two-stage synchronizer, and the synchronized level is sampled at the last cycle of each settle window. For each line the block drives an enable (`drv_en_o`) and a level (`drv_val_o`). Outside the charge phase, an enabled line is always driven low, and the pad releases the line when the enable is clear. The charge time and the settle time are parameters counted in clock cycles.

There is no back-pressure anywhere. The sense code is a registered result that `done_o` qualifies, and it stays valid indefinitely, so a consumer may capture it at any time after the pulse. `start_i` is a plain request and is taken only while the sequencer is idle. Bit index 0, 1 and 2 of every 3-bit line vector is line A, B and C respectively.

Top module: `monsense_seq`

## Requirements
- R1: After reset, `drv_en_o`, `drv_val_o`, `done_o` and `code_o` are all zero.
- R2: For `CHARGE_CYC` cycles following the clock edge that accepts `start_i`, `drv_en_o` and `drv_val_o` are both 3'b111.
- R3: The next `SETTLE_CYC` cycles have every driver released (`drv_en_o` = 0). At the end of this window, the synchronized levels of C, B and A are stored in code bits 10, 9 and 8.
- R4: Three pull windows of `SETTLE_CYC` cycles each follow, in the order A, B, C. During each window only the pulled line's enable is set and `drv_val_o` is 0.
- R5: At the end of the A window, C goes to code bit 5 and B to bit 4. At the end of the B window, C goes to bit 3 and A to bit 2. At the end of the C window, B goes to bit 1 and A to bit 0.
- R6: Code bits 7 and 6 always read zero.
- R7: `done_o` is high for exactly one cycle, `CHARGE_CYC + 4*SETTLE_CYC` cycles after the accepting edge. From that cycle on, all drivers are released.
- R8: `code_o` changes only in the cycle in which `done_o` is high. A `start_i` during a running probe is ignored, so the timing of the probe is unchanged.
- R9: Only the synchronized level at the end of each window is used. A line disturbance that ends three or more cycles before the end of a window has no effect on the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Probe request, taken when idle |
| line_i | input | 3 | Raw levels of lines C,B,A (bits 2..0) |
| drv_en_o | output | 3 | Per-line driver enable |
| drv_val_o | output | 3 | Per-line driven level |
| done_o | output | 1 | One-cycle probe-complete pulse |
| code_o | output | 11 | Packed sense code |

## Verification
The sequencer can enter a wrong phase, and the settle counter can be misloaded. Either fault shows up at the driver pins within one cycle, as the wrong enable pattern, or at `done_o` as a pulse that comes at the wrong cycle count. A wrong sample strobe or a wrong bit placement is visible only once the probe finishes. It then shows as a code that disagrees with the modelled line wiring (grounded lines and shorted line pairs). A stale result register shows as a change of `code_o` outside the done pulse.

// File: rtl/monsense_pkg.sv
package monsense_pkg;
  localparam int NLINES = 3;
  localparam int CODE_W = 11;
  localparam int LA = 0;
  localparam int LB = 1;
  localparam int LC = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHARGE,
    PH_FLOAT,
    PH_PULL_A,
    PH_PULL_B,
    PH_PULL_C
  } phase_e;
endpackage

// File: rtl/monsense_sync.sv
module monsense_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/monsense_timer.sv
module monsense_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load_i)      cnt <= load_val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/monsense_ctrl.sv
module monsense_ctrl
  import monsense_pkg::*;
#(
  parameter int CHARGE_CYC = 200,
  parameter int SETTLE_CYC = 2000,
  parameter int W          = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              zero_i,
  output phase_e            phase_o,
  output logic              load_o,
  output logic [W-1:0]      load_val_o,
  output logic              stb_o,
  output logic [NLINES-1:0] drv_en_o,
  output logic [NLINES-1:0] drv_val_o
);
  localparam logic [W-1:0] CHARGE_LD = W'(CHARGE_CYC - 1);
  localparam logic [W-1:0] SETTLE_LD = W'(SETTLE_CYC - 1);

  phase_e phase, phase_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

  always_comb begin
    phase_nxt  = phase;
    load_o     = 1'b0;
    load_val_o = SETTLE_LD;
    stb_o      = 1'b0;
    unique case (phase)
      PH_IDLE: if (start_i) begin
        phase_nxt  = PH_CHARGE;
        load_o     = 1'b1;
        load_val_o = CHARGE_LD;
      end
      PH_CHARGE: if (zero_i) begin
        phase_nxt = PH_FLOAT;
        load_o    = 1'b1;
      end
      PH_FLOAT: if (zero_i) begin
        phase_nxt = PH_PULL_A;
        load_o    = 1'b1;
        stb_o     = 1'b1;
      end
      PH_PULL_A: if (zero_i) begin
        phase_nxt = PH_PULL_B;
        load_o    = 1'b1;
        stb_o     = 1'b1;
      end
      PH_PULL_B: if (zero_i) begin
        phase_nxt = PH_PULL_C;
        load_o    = 1'b1;
        stb_o     = 1'b1;
      end
      PH_PULL_C: if (zero_i) begin
        phase_nxt = PH_IDLE;
        stb_o     = 1'b1;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    drv_en_o  = '0;
    drv_val_o = '0;
    case (phase)
      PH_CHARGE: begin
        drv_en_o  = '1;
        drv_val_o = '1;
      end
      PH_PULL_A: drv_en_o[LA] = 1'b1;
      PH_PULL_B: drv_en_o[LB] = 1'b1;
      PH_PULL_C: drv_en_o[LC] = 1'b1;
      default: ;
    endcase
  end

  assign phase_o = phase;
endmodule

// File: rtl/monsense_pack.sv
module monsense_pack
  import monsense_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic              stb_i,
  input  logic [NLINES-1:0] lvl_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:2] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      code_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (stb_i) begin
        case (phase_i)
          PH_FLOAT: begin
            shadow        <= '0;
            shadow[10:8]  <= {lvl_i[LC], lvl_i[LB], lvl_i[LA]};
          end
          PH_PULL_A: shadow[5:4] <= {lvl_i[LC], lvl_i[LB]};
          PH_PULL_B: shadow[3:2] <= {lvl_i[LC], lvl_i[LA]};
          PH_PULL_C: begin
            code_o <= {shadow, lvl_i[LB], lvl_i[LA]};
            done_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/monsense_seq.sv
module monsense_seq
  import monsense_pkg::*;
#(
  parameter int CHARGE_CYC  = 200,
  parameter int SETTLE_CYC  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        line_i,
  output logic [2:0]        drv_en_o,
  output logic [2:0]        drv_val_o,
  output logic              done_o,
  output logic [10:0]       code_o
);
  localparam int MAX_CYC = (CHARGE_CYC > SETTLE_CYC) ? CHARGE_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  logic [NLINES-1:0] lvl_s;
  logic              tmr_load, tmr_zero, smp_stb;
  logic [CNT_W-1:0]  tmr_val;
  phase_e            phase;

  monsense_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(lvl_s)
  );

  monsense_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .zero_o(tmr_zero)
  );

  monsense_ctrl #(.CHARGE_CYC(CHARGE_CYC), .SETTLE_CYC(SETTLE_CYC), .W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero_i(tmr_zero),
    .phase_o(phase), .load_o(tmr_load), .load_val_o(tmr_val), .stb_o(smp_stb),
    .drv_en_o(drv_en_o), .drv_val_o(drv_val_o)
  );

  monsense_pack u_pack (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .stb_i(smp_stb), .lvl_i(lvl_s),
    .done_o(done_o), .code_o(code_o)
  );
endmodule

// File: rtl/monsense_seq_chk.sv
module monsense_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [2:0]  drv_en_o,
  input logic [2:0]  drv_val_o,
  input logic        done_o,
  input logic [10:0] code_o
);
  // R6
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    code_o[7:6] == 2'b00);
  // R7
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> drv_en_o == 3'b000);
  // R2
  a_r2_charge_high: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_o == 3'b111) |-> (drv_val_o == 3'b111));
  // R4
  a_r4_single_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_o != 3'b111) |-> ($onehot0(drv_en_o) && drv_val_o == 3'b000));
  // R8
  a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> done_o);
endmodule

bind monsense_seq monsense_seq_chk u_chk (.*);

// File: tb/monsense_seq_tb.sv
module monsense_seq_tb;
  localparam int HI    = 8;
  localparam int ST    = 24;
  localparam int TOTAL = HI + 4 * ST;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  line_i;
  logic [2:0]  drv_en_o, drv_val_o;
  logic        done_o;
  logic [10:0] code_o;

  logic [2:0] gnd = 3'b000;
  logic [2:0] glitch = 3'b000;
  logic sab = 1'b0, sac = 1'b0, sbc = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  monsense_seq #(.CHARGE_CYC(HI), .SETTLE_CYC(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
    .drv_en_o(drv_en_o), .drv_val_o(drv_val_o), .done_o(done_o), .code_o(code_o)
  );

  // Wired line model: pulled up, ground straps, shorted pairs.
  logic [2:0] lo, hi;
  always_comb begin
    lo = drv_en_o & ~drv_val_o;
    hi = drv_en_o & drv_val_o;
    line_i[0] = hi[0] | !(gnd[0] | glitch[0] | lo[0] | (sab & lo[1]) | (sac & lo[2]));
    line_i[1] = hi[1] | !(gnd[1] | glitch[1] | lo[1] | (sab & lo[0]) | (sbc & lo[2]));
    line_i[2] = hi[2] | !(gnd[2] | glitch[2] | lo[2] | (sac & lo[0]) | (sbc & lo[1]));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_code();
    logic [10:0] c = '0;
    c[10] = !gnd[2]; c[9] = !gnd[1]; c[8] = !gnd[0];
    c[5]  = !(gnd[2] | sac); c[4] = !(gnd[1] | sab);
    c[3]  = !(gnd[2] | sbc); c[2] = !(gnd[0] | sab);
    c[1]  = !(gnd[1] | sbc); c[0] = !(gnd[0] | sac);
    return c;
  endfunction

  task automatic t_reset();
    #1;
    chk(drv_en_o == 0, "R1", "drv_en at reset", 32'(drv_en_o), 0);
    chk(drv_val_o == 0, "R1", "drv_val at reset", 32'(drv_val_o), 0);
    chk(done_o == 0, "R1", "done at reset", 32'(done_o), 0);
    chk(code_o == 0, "R1", "code at reset", 32'(code_o), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_probe(input logic [2:0] g, input bit ab, input bit ac, input bit bc,
                         input bit poke, input bit glt, input string tag);
    logic [10:0] prev, exp;
    int bad_chg = 0, bad_flt = 0, bad_pull = 0, bad_done = 0, bad_hold = 0;
    logic [2:0] e_en;
    gnd = g; sab = ab; sac = ac; sbc = bc;
    exp = exp_code();
    @(negedge clk); start_i = 1'b1;
    prev = code_o;
    for (int i = 1; i <= TOTAL + 1; i++) begin
      @(negedge clk);
      start_i = poke && (i == HI + 3);
      glitch  = (glt && i >= HI + 1 && i < HI + ST / 2) ? 3'b111 : 3'b000;
      if (i <= HI) begin
        if (drv_en_o != 3'b111 || drv_val_o != 3'b111) bad_chg++;
      end else if (i <= HI + ST) begin
        if (drv_en_o != 3'b000) bad_flt++;
      end else if (i <= TOTAL) begin
        e_en = (i <= HI + 2 * ST) ? 3'b001 : (i <= HI + 3 * ST) ? 3'b010 : 3'b100;
        if (drv_en_o != e_en || drv_val_o != 3'b000) bad_pull++;
      end
      if (done_o != (i == TOTAL + 1)) bad_done++;
      if (i <= TOTAL && code_o != prev) bad_hold++;
    end
    start_i = 1'b0;
    chk(bad_chg == 0, "R2", {tag, " charge pattern"}, bad_chg, 0);
    chk(bad_flt == 0, "R3", {tag, " float release"}, bad_flt, 0);
    chk(bad_pull == 0, "R4", {tag, " pull order A,B,C"}, bad_pull, 0);
    chk(bad_done == 0, "R7", {tag, " done timing"}, bad_done, 0);
    chk(drv_en_o == 0, "R7", {tag, " release at done"}, 32'(drv_en_o), 0);
    chk(bad_hold == 0, "R8", {tag, " code held during probe"}, bad_hold, 0);
    chk(code_o == exp, glt ? "R9" : "R5", {tag, " sense code"}, 32'(code_o), 32'(exp));
    chk(code_o[7:6] == 0, "R6", {tag, " pad bits"}, 32'(code_o[7:6]), 0);
    @(negedge clk);
    chk(done_o == 0, "R7", {tag, " done single cycle"}, 32'(done_o), 0);
  endtask

  task automatic t_hold_idle();
    logic [10:0] keep = code_o;
    gnd = ~gnd; sab = 1'b1;
    repeat (40) @(negedge clk);
    chk(code_o == keep, "R8", "code held while idle", 32'(code_o), 32'(keep));
    chk(done_o == 0, "R8", "no done while idle", 32'(done_o), 0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_probe(3'b000, 0, 0, 0, 0, 0, "open");
    t_probe(3'b101, 0, 0, 0, 0, 0, "gnd A,C");
    t_probe(3'b000, 1, 0, 0, 0, 0, "short AB");
    t_probe(3'b000, 0, 1, 1, 0, 0, "short AC,BC");
    t_probe(3'b010, 0, 1, 0, 1, 0, "restart ignored");
    t_probe(3'b000, 1, 0, 0, 0, 1, "glitch");
    t_hold_idle();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule